// File: doc/BRIEF.md
# Eight-Line Cascadable Priority Interrupt Controller

This block collects up to eight interrupt request lines, captures a rising edge on each of them, and presents the highest-priority pending request to a processor. Line 0 has the highest priority and line 7 the lowest. When the processor acknowledges, the winning request moves from the pending set into the in-service set. The block then delivers an 8-bit vector, which is a programmed base plus the line number.

Software reaches the block through a one-bit address. Address 0 is the command address and address 1 is the auxiliary address. Software first writes a start word to the command address. The words that follow go to the auxiliary address and are told apart only by the order in which they arrive: the vector base, then an optional cascade word, then an optional mode word. After that, auxiliary writes load the interrupt mask. Command-address writes then carry either an end-of-interrupt or a read-select command.

The same block can act as a master or as a slave in a cascaded pair. On a master, the cascade word lists the lines that have slaves attached. On a slave, it gives the slave's own identity. Software gives the slave a base 8 above the master's base and sends end-of-interrupt to both devices.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A command-address write with bit 4 set restarts setup. On the next cycle the request, in-service and mask registers are zero, `ready` is low, and command-address reads select the request register.
- R2: The first auxiliary word after the start word sets the vector base. An acknowledged line n yields `vector_out` = (base + n) mod 256 on the cycle after the acknowledge.
- R3: The start word's bit 1 tells whether the device is part of a cascade. Bit 1 clear means a cascade word follows the base, and its value appears on `casc_cfg`. Bit 1 set means no cascade word is expected.
- R4: The start word's bit 0 set means a mode word follows, and `ready` rises only after that word arrives. Bit 0 clear means `ready` rises after the last word that is expected. While `ready` is low, `int_out` stays low.
- R5: When `ready` is high, an auxiliary write loads the mask, and auxiliary reads return it. A masked line still latches into the request register but cannot raise `int_out`.
- R6: A command-address write with bits 4:3 = 01 is a read-select word. Low bits 11 make command reads return the in-service register, low bits 10 make them return the request register, and other values leave the selection unchanged.
- R7: A request bit is set only on a low-to-high transition of its line. A line held high after its acknowledge does not set the bit again.
- R8: Among the unmasked pending requests, the lowest line number wins and is the one acknowledged.
- R9: `int_out` is high only when the winning request has a lower line number than every in-service bit.
- R10: `int_ack` while `int_out` is high sets the winner's in-service bit and clears its request bit. `int_ack` while `int_out` is low changes nothing.
- R11: A command-address write with bits 4:3 = 00 and bits 7:5 = 001 clears the lowest-numbered set in-service bit. Other codes in bits 7:5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = auxiliary address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_in | input | 8 | Asynchronous interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| vector_out | output | 8 | Vector of the most recently acknowledged line |
| casc_cfg | output | 8 | Stored cascade word |
| ready | output | 1 | Setup sequence complete |

## Verification
A corrupted setup state shows up at once. Either `ready` rises at the wrong word, or a later auxiliary word lands in the base instead of the mask, and that gives a wrong vector at the next acknowledge. A wrong in-service bit shows within a cycle as `int_out` being raised or held back in the wrong place among nested requests, and the in-service read-back then confirms it. A lost or duplicated request bit shows as a missing or extra vector in the scoreboard queue, either at the next acknowledge or at the end of the run.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NLINES = 8;
    localparam int DW     = 8;
    localparam int IDXW   = $clog2(NLINES);

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_RUN
    } init_st_e;

    typedef enum logic {
        RD_REQ,
        RD_SVC
    } rd_sel_e;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
    } pick_t;

    // Lowest-numbered set bit wins.
    function automatic pick_t lowest_set(input logic [NLINES-1:0] v);
        pick_t p;
        p.valid = 1'b0;
        p.idx   = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = IDXW'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/irq_prog_seq.sv
module irq_prog_seq
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    output logic              init_start,
    output logic              ready,
    output logic              eoi_cmd,
    output logic [DW-1:0]     base,
    output logic [NLINES-1:0] mask,
    output logic [DW-1:0]     casc,
    output rd_sel_e           rd_sel
);
    init_st_e state;
    logic     need_mode;
    logic     single;
    logic     wr_cmd, wr_aux;

    assign wr_cmd     = wr & ~addr;
    assign wr_aux     = wr & addr;
    assign init_start = wr_cmd & wdata[4];
    assign ready      = (state == ST_RUN);
    assign eoi_cmd    = ready & wr_cmd & (wdata[4:3] == 2'b00) & (wdata[7:5] == 3'b001);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_UNINIT;
            need_mode <= 1'b0;
            single    <= 1'b0;
            base      <= '0;
            mask      <= '0;
            casc      <= '0;
            rd_sel    <= RD_REQ;
        end else if (init_start) begin
            state     <= ST_BASE;
            need_mode <= wdata[0];
            single    <= wdata[1];
            mask      <= '0;
            rd_sel    <= RD_REQ;
        end else begin
            case (state)
                ST_BASE: if (wr_aux) begin
                    base  <= wdata;
                    state <= !single ? ST_CASC : (need_mode ? ST_MODE : ST_RUN);
                end
                ST_CASC: if (wr_aux) begin
                    casc  <= wdata;
                    state <= need_mode ? ST_MODE : ST_RUN;
                end
                ST_MODE: if (wr_aux) begin
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    if (wr_aux) mask <= wdata[NLINES-1:0];
                    if (wr_cmd && wdata[4:3] == 2'b01) begin
                        if (wdata[1:0] == 2'b11)      rd_sel <= RD_SVC;
                        else if (wdata[1:0] == 2'b10) rd_sel <= RD_REQ;
                    end
                end
                default: state <= ST_UNINIT;
            endcase
        end
    end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [NLINES-1:0] lines,
    input  logic [NLINES-1:0] ack_clr,
    output logic [NLINES-1:0] irr
);
    logic [NLINES-1:0] sync1, sync2, prev;
    logic [NLINES-1:0] rise;

    assign rise = sync2 & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
            irr   <= '0;
        end else begin
            sync1 <= lines;
            sync2 <= sync1;
            prev  <= sync2;
            if (clear) irr <= '0;
            else       irr <= (irr & ~ack_clr) | rise;
        end
    end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_prio_pkg::*;
(
    input  logic              ready,
    input  logic [NLINES-1:0] irr,
    input  logic [NLINES-1:0] mask,
    input  logic [NLINES-1:0] isr,
    output pick_t             win,
    output pick_t             svc_top,
    output logic              int_req
);
    assign win     = lowest_set(irr & ~mask);
    assign svc_top = lowest_set(isr);
    assign int_req = ready & win.valid & (!svc_top.valid || (win.idx < svc_top.idx));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    irq_in,
    output logic          int_out,
    input  logic          int_ack,
    output logic [7:0]    vector_out,
    output logic [7:0]    casc_cfg,
    output logic          ready
);
    logic              init_start, eoi_cmd, ack_ok;
    logic [DW-1:0]     base;
    logic [NLINES-1:0] mask_q, irr_q, isr_q, ack_clr, eoi_clr;
    rd_sel_e           rd_sel;
    pick_t             win, svc_top;
    logic [DW-1:0]     vec_q;

    irq_prog_seq u_seq (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .init_start(init_start), .ready(ready), .eoi_cmd(eoi_cmd),
        .base(base), .mask(mask_q), .casc(casc_cfg), .rd_sel(rd_sel)
    );

    irq_edge_latch u_edge (
        .clk(clk), .rst(rst), .clear(init_start), .lines(irq_in),
        .ack_clr(ack_clr), .irr(irr_q)
    );

    irq_prio_resolve u_res (
        .ready(ready), .irr(irr_q), .mask(mask_q), .isr(isr_q),
        .win(win), .svc_top(svc_top), .int_req(int_out)
    );

    assign ack_ok  = int_ack & int_out;
    assign ack_clr = ack_ok ? (NLINES'(1) << win.idx) : '0;
    assign eoi_clr = (eoi_cmd && svc_top.valid) ? (NLINES'(1) << svc_top.idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            vec_q <= '0;
        end else begin
            if (init_start) isr_q <= '0;
            else            isr_q <= (isr_q & ~eoi_clr) | ack_clr;
            if (ack_ok) vec_q <= base + DW'(win.idx);
        end
    end

    assign vector_out = vec_q;
    assign bus_rdata  = bus_addr ? mask_q : ((rd_sel == RD_SVC) ? isr_q : irr_q);
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
    input logic       clk,
    input logic       rst,
    input logic       int_out,
    input logic       int_ack,
    input logic       ready,
    input logic       init_start,
    input logic       eoi,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [7:0] mask
);
    a_r4_quiet_until_ready: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ready);

    a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
        init_start |=> (irr == 8'h00 && isr == 8'h00 && mask == 8'h00 && !int_out));

    a_r5_int_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~mask) != 8'h00));

    a_r10_ack_adds_one: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_out && !eoi && !init_start)
        |=> $countones(isr) == $countones($past(isr)) + 1);

    a_r11_eoi_drops_one: assert property (@(posedge clk) disable iff (rst)
        (eoi && !(int_ack && int_out) && isr != 8'h00)
        |=> $countones(isr) + 1 == $countones($past(isr)));
endmodule

bind irq_prio_ctrl irq_prio_chk chk_i (
    .clk(clk), .rst(rst), .int_out(int_out), .int_ack(int_ack), .ready(ready),
    .init_start(init_start), .eoi(eoi_cmd), .irr(irr_q), .isr(isr_q), .mask(mask_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/100ps
module irq_prio_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] vector_out;
    logic [7:0] casc_cfg;
    logic       ready;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic  ack_d = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_out(int_out), .int_ack(int_ack), .vector_out(vector_out),
        .casc_cfg(casc_cfg), .ready(ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input string tag, input int exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // Driver: acknowledges and queues the vector the requirements predict.
    task automatic ack(input int exp, input string tag);
        @(negedge clk);
        int_ack = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic ack_ignored();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    // Monitor: one vector per accepted acknowledge.
    always @(posedge clk) ack_d <= int_ack & int_out;
    always @(negedge clk) begin
        if (ack_d) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected acknowledge", 1, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, vector_out, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R4 reset int_out", int_out, 0);
        chk("R4 reset ready", ready, 0);
        rd(1'b0, "R1 reset request reg", 8'h00);

        // Master setup: cascade, mode word follows.
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h04);
        chk("R4 not ready before mode word", ready, 0);
        wr(1'b1, 8'h01);
        chk("R4 ready after mode word", ready, 1);
        chk("R3 master cascade word", casc_cfg, 8'h04);
        rd(1'b0, "R6 default read request reg", 8'h00);
        rd(1'b1, "R5 mask after setup", 8'h00);

        // Two simultaneous edges.
        irq_in = 8'h24; settle();
        rd(1'b0, "R7 edges latched", 8'h24);
        chk("R8 int_out pending", int_out, 1);
        ack(8'h42, "R8 line 2 wins vector");
        @(negedge clk);
        chk("R9 lower priority held back", int_out, 0);
        wr(1'b0, 8'h0B);
        rd(1'b0, "R6 in-service select", 8'h04);
        wr(1'b0, 8'h0A);
        rd(1'b0, "R7 held line not relatched", 8'h20);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h08);
        rd(1'b0, "R6 other low bits keep select", 8'h04);

        wr(1'b0, 8'h60);
        rd(1'b0, "R11 other code no effect", 8'h04);
        wr(1'b0, 8'h20);
        rd(1'b0, "R11 EOI clears", 8'h00);
        chk("R9 line 5 now allowed", int_out, 1);
        ack(8'h45, "R2 line 5 vector");
        @(negedge clk);
        chk("R10 int_out low after ack", int_out, 0);
        ack_ignored();
        rd(1'b0, "R10 ignored ack leaves in-service", 8'h20);
        wr(1'b0, 8'h20);

        // Mask and nesting.
        irq_in = 8'h00; settle();
        wr(1'b1, 8'h01);
        rd(1'b1, "R5 mask readback", 8'h01);
        irq_in = 8'h09; settle();
        wr(1'b0, 8'h0A);
        rd(1'b0, "R5 masked line still latched", 8'h09);
        ack(8'h43, "R5 masked line skipped");
        @(negedge clk);
        chk("R5 masked line no int", int_out, 0);
        wr(1'b1, 8'h00);
        chk("R9 nested higher priority", int_out, 1);
        ack(8'h40, "R9 nested vector");
        wr(1'b0, 8'h0B);
        rd(1'b0, "R10 two in service", 8'h09);
        wr(1'b0, 8'h20);
        rd(1'b0, "R11 lowest bit cleared first", 8'h08);
        wr(1'b0, 8'h20);
        rd(1'b0, "R11 second EOI", 8'h00);

        // Restart mid-operation: single device, no mode word.
        irq_in = 8'h49; settle();
        wr(1'b0, 8'h12);
        chk("R1 ready drops", ready, 0);
        chk("R1 int_out low", int_out, 0);
        rd(1'b0, "R1 request cleared and select reset", 8'h00);
        wr(1'b1, 8'hFC);
        chk("R3 no cascade word in single mode", ready, 1);
        wr(1'b1, 8'h80);
        rd(1'b1, "R5 mask after restart", 8'h80);
        irq_in = 8'h00; settle();
        irq_in = 8'hC0; settle();
        rd(1'b0, "R5 masked line 7 latched", 8'hC0);
        ack(8'h02, "R2 base wraps");

        // Slave setup.
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h48);
        wr(1'b1, 8'h02);
        chk("R4 slave waits for mode word", ready, 0);
        wr(1'b1, 8'h01);
        chk("R3 slave identity", casc_cfg, 8'h02);
        irq_in = 8'h00; settle();
        irq_in = 8'h01; settle();
        ack(8'h48, "R2 slave base vector");
        repeat (2) @(negedge clk);
        chk("R10 all vectors delivered", exp_q.size(), 0);
        finish_run();
    end
endmodule